// File: doc/BRIEF.md
# Two-Port Shared Memory with Per-Port Controls

This block is a 4096-location, 8-bit-wide memory that two independent agents reach through a left port and a right port. Each port has a 12-bit address, write data, read data, and three active-low controls: select, write strobe (low writes, high reads) and output gate. Either port can reach every location. There is no arbitration and no wait signalling. Two accesses to the same location in the same cycle are resolved by a fixed rule.

The bidirectional pins of a discrete part are modelled here as a read-data bus plus a drive flag per port. A parent with real pads builds its tri-state buffers from these. Every port action is sampled on a shared clock. Each port's controls fall into one of four modes: deselected (standby), write, read, or outputs off. Per-port and whole-block standby flags report which select lines are inactive.

Top module: `dual_port_mem`

## Requirements
- R1: While reset is active and after it is released, with no accesses, both drive flags are 0, both read-data buses are 0x00, the collision flag is 0, and the standby flags are 1.
- R2: A port with select low and write strobe low stores its write data at its address on the clock edge, whatever its output gate is.
- R3: A port with select low, write strobe high and output gate low sets its drive flag to 1 one cycle later, and its read data then shows the stored byte.
- R4: A port with select high neither stores data nor drives, whatever its write strobe and output gate are.
- R5: When a port's drive flag is 0, its read-data bus is 0x00. A selected read with the output gate high leaves the drive flag at 0.
- R6: The cycle after a write on a port, that port's drive flag is 0.
- R7: A byte written on one port can be read on the other port at the same address, including addresses 0x000 and 0xFFF.
- R8: When both ports write the same address in the same cycle, the left port's byte is kept. The collision flag is 1 for exactly the following cycle.
- R9: When one port writes an address in the same cycle that the other port reads it, the reader gets the byte stored before that write.
- R10: Each port's standby flag equals that port's select input from the previous cycle. The whole-block standby flag is 1 only when both selects were high in the previous cycle.
- R11: Writes from both ports to different addresses in the same cycle both take effect, and the collision flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared sampling clock |
| rst_n | input | 1 | Active-low reset of the output registers |
| lt_sel_n | input | 1 | Left select, active low |
| lt_wr_n | input | 1 | Left write strobe: 0 writes, 1 reads |
| lt_oe_n | input | 1 | Left output gate, active low |
| lt_addr | input | 12 | Left address |
| lt_wdata | input | 8 | Left write data |
| lt_rdata | output | 8 | Left read data |
| lt_drive | output | 1 | Left bus driven |
| rt_sel_n | input | 1 | Right select, active low |
| rt_wr_n | input | 1 | Right write strobe: 0 writes, 1 reads |
| rt_oe_n | input | 1 | Right output gate, active low |
| rt_addr | input | 12 | Right address |
| rt_wdata | input | 8 | Right write data |
| rt_rdata | output | 8 | Right read data |
| rt_drive | output | 1 | Right bus driven |
| lt_standby | output | 1 | Left port deselected in the previous cycle |
| rt_standby | output | 1 | Right port deselected in the previous cycle |
| all_standby | output | 1 | Both ports deselected in the previous cycle |
| collide | output | 1 | Same-address double write in the previous cycle |

## Verification
All results, including read data, drive flags, standby flags and the collision flag, appear exactly one clock after the controls that cause them. A stored byte becomes visible only through a later read, which lands one further clock on. The bench applies each stimulus row on a falling edge and compares outputs on the next falling edge, one rising edge later. Same-cycle conflicts and ignored writes are therefore judged through reads in the rows that follow. A row of idle cycles separates each pattern from its check where the ordering matters.

// File: rtl/dual_port_mem.sv
`timescale 1ns/1ps
module dual_port_mem #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lt_sel_n,
  input  logic          lt_wr_n,
  input  logic          lt_oe_n,
  input  logic [AW-1:0] lt_addr,
  input  logic [DW-1:0] lt_wdata,
  output logic [DW-1:0] lt_rdata,
  output logic          lt_drive,
  input  logic          rt_sel_n,
  input  logic          rt_wr_n,
  input  logic          rt_oe_n,
  input  logic [AW-1:0] rt_addr,
  input  logic [DW-1:0] rt_wdata,
  output logic [DW-1:0] rt_rdata,
  output logic          rt_drive,
  output logic          lt_standby,
  output logic          rt_standby,
  output logic          all_standby,
  output logic          collide
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  wire lt_wr = !lt_sel_n && !lt_wr_n;
  wire rt_wr = !rt_sel_n && !rt_wr_n;
  wire lt_rd = !lt_sel_n && lt_wr_n && !lt_oe_n;
  wire rt_rd = !rt_sel_n && rt_wr_n && !rt_oe_n;
  wire clash = lt_wr && rt_wr && (lt_addr == rt_addr);

  // right written first so the left write wins on a shared address
  always_ff @(posedge clk) begin
    if (rt_wr) mem[rt_addr] <= rt_wdata;
    if (lt_wr) mem[lt_addr] <= lt_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lt_rdata    <= '0;
      rt_rdata    <= '0;
      lt_drive    <= 1'b0;
      rt_drive    <= 1'b0;
      lt_standby  <= 1'b1;
      rt_standby  <= 1'b1;
      all_standby <= 1'b1;
      collide     <= 1'b0;
    end else begin
      lt_rdata    <= lt_rd ? mem[lt_addr] : '0;
      rt_rdata    <= rt_rd ? mem[rt_addr] : '0;
      lt_drive    <= lt_rd;
      rt_drive    <= rt_rd;
      lt_standby  <= lt_sel_n;
      rt_standby  <= rt_sel_n;
      all_standby <= lt_sel_n && rt_sel_n;
      collide     <= clash;
    end
  end

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_LT_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lt_drive |-> lt_rdata == '0);  // R5
  AST_RT_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_drive |-> rt_rdata == '0);  // R5
  AST_LT_DRIVE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    lt_drive |-> !lt_standby);  // R4
  AST_RT_DRIVE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    rt_drive |-> !rt_standby);  // R4
  AST_ALL_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    all_standby == (lt_standby && rt_standby));  // R10
  AST_LT_NO_DRIVE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!lt_sel_n && !lt_wr_n) |-> !lt_drive);  // R6
  AST_RT_NO_DRIVE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!rt_sel_n && !rt_wr_n) |-> !rt_drive);  // R6
  AST_COLLIDE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    armed && collide |-> $past(!lt_sel_n && !lt_wr_n && !rt_sel_n && !rt_wr_n
                               && lt_addr == rt_addr));  // R8
endmodule

// File: tb/dual_port_mem_test.sv
`timescale 1ns/1ps
module dual_port_mem_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lsel = 1'b1, lwr = 1'b1, loe = 1'b1, rsel = 1'b1, rwr = 1'b1, roe = 1'b1;
  logic [11:0] laddr = '0, raddr = '0;
  logic [7:0] lwd = '0, rwd = '0;
  logic [7:0] lq, rq;
  logic ldrv, rdrv, lsb, rsb, asb, col;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_port_mem uut (
    .clk(clk), .rst_n(rst_n),
    .lt_sel_n(lsel), .lt_wr_n(lwr), .lt_oe_n(loe), .lt_addr(laddr), .lt_wdata(lwd),
    .lt_rdata(lq), .lt_drive(ldrv),
    .rt_sel_n(rsel), .rt_wr_n(rwr), .rt_oe_n(roe), .rt_addr(raddr), .rt_wdata(rwd),
    .rt_rdata(rq), .rt_drive(rdrv),
    .lt_standby(lsb), .rt_standby(rsb), .all_standby(asb), .collide(col)
  );

  typedef struct packed {
    logic lc, lw, lo; logic [11:0] la; logic [7:0] ld;
    logic rc, rw, ro; logic [11:0] ra; logic [7:0] rd;
    logic eld; logic [7:0] elq; logic erd; logic [7:0] erq; logic ec;
  } vec_t;

  localparam int N = 17;
  localparam vec_t VEC [N] = '{
    '{0,0,0,12'h005,8'hA5, 1,1,1,12'h000,8'h00, 0,8'h00,0,8'h00,0},
    '{1,1,1,12'h000,8'h00, 0,1,0,12'h005,8'h00, 0,8'h00,1,8'hA5,0},
    '{0,1,0,12'h005,8'h00, 0,0,1,12'h0FF,8'h3C, 1,8'hA5,0,8'h00,0},
    '{0,1,0,12'h0FF,8'h00, 0,1,1,12'h0FF,8'h00, 1,8'h3C,0,8'h00,0},
    '{1,0,0,12'h005,8'h11, 1,1,1,12'h000,8'h00, 0,8'h00,0,8'h00,0},
    '{1,1,1,12'h000,8'h00, 0,1,0,12'h005,8'h00, 0,8'h00,1,8'hA5,0},
    '{0,0,1,12'h123,8'h77, 1,1,1,12'h000,8'h00, 0,8'h00,0,8'h00,0},
    '{0,1,0,12'h123,8'h00, 0,0,0,12'h123,8'h88, 1,8'h77,0,8'h00,0},
    '{0,1,0,12'h123,8'h00, 1,1,1,12'h000,8'h00, 1,8'h88,0,8'h00,0},
    '{0,0,1,12'h200,8'h5A, 0,0,1,12'h200,8'hC3, 0,8'h00,0,8'h00,1},
    '{0,1,0,12'h200,8'h00, 0,1,0,12'h200,8'h00, 1,8'h5A,1,8'h5A,0},
    '{0,0,1,12'h010,8'h01, 0,0,1,12'h011,8'h02, 0,8'h00,0,8'h00,0},
    '{0,1,0,12'h011,8'h00, 0,1,0,12'h010,8'h00, 1,8'h02,1,8'h01,0},
    '{0,0,1,12'hFFF,8'hE1, 0,0,1,12'h000,8'h1E, 0,8'h00,0,8'h00,0},
    '{0,1,0,12'h000,8'h00, 0,1,0,12'hFFF,8'h00, 1,8'h1E,1,8'hE1,0},
    '{1,1,1,12'h000,8'h00, 1,0,0,12'hFFF,8'h99, 0,8'h00,0,8'h00,0},
    '{0,1,0,12'hFFF,8'h00, 1,1,1,12'h000,8'h00, 1,8'hE1,0,8'h00,0}
  };
  localparam string TAG [N] = '{
    "R2 R6", "R7 R3", "R3 R6", "R5", "R4", "R4 R7", "R2", "R9", "R9 R2",
    "R8", "R8", "R11", "R11", "R7 R2", "R7", "R4", "R4"
  };

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    lsel = 1'b1; lwr = 1'b1; loe = 1'b1; rsel = 1'b1; rwr = 1'b1; roe = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1", "ldrive in reset", {7'd0, ldrv}, 8'h00);
    check("R1", "rdata in reset", rq, 8'h00);
    check("R1", "all_standby in reset", {7'd0, asb}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "collide after reset", {7'd0, col}, 8'h00);
    check("R1", "lstandby after reset", {7'd0, lsb}, 8'h01);
    check("R1", "ldata after reset", lq, 8'h00);

    for (int i = 0; i < N; i++) begin
      lsel = VEC[i].lc; lwr = VEC[i].lw; loe = VEC[i].lo; laddr = VEC[i].la; lwd = VEC[i].ld;
      rsel = VEC[i].rc; rwr = VEC[i].rw; roe = VEC[i].ro; raddr = VEC[i].ra; rwd = VEC[i].rd;
      @(negedge clk);
      check(TAG[i], "ldrive", {7'd0, ldrv}, {7'd0, VEC[i].eld});
      check(TAG[i], "ldata", lq, VEC[i].elq);
      check(TAG[i], "rdrive", {7'd0, rdrv}, {7'd0, VEC[i].erd});
      check(TAG[i], "rdata", rq, VEC[i].erq);
      check(TAG[i], "collide", {7'd0, col}, {7'd0, VEC[i].ec});
      check("R10", "lstandby", {7'd0, lsb}, {7'd0, VEC[i].lc});
      check("R10", "rstandby", {7'd0, rsb}, {7'd0, VEC[i].rc});
      check("R10", "all_standby", {7'd0, asb}, {7'd0, VEC[i].lc & VEC[i].rc});
    end

    // R8: collision flag lasts one cycle only
    lsel = 0; lwr = 0; loe = 1; laddr = 12'h300; lwd = 8'h42;
    rsel = 0; rwr = 0; roe = 1; raddr = 12'h300; rwd = 8'h24;
    @(negedge clk);
    idle();
    check("R8", "collide pulse", {7'd0, col}, 8'h01);
    @(negedge clk);
    check("R8", "collide cleared", {7'd0, col}, 8'h00);

    // R10: only one port deselected
    lsel = 0; lwr = 1; loe = 1;
    @(negedge clk);
    check("R10", "mixed all_standby", {7'd0, asb}, 8'h00);
    check("R5", "oe high no drive", {7'd0, ldrv}, 8'h00);

    // R1: reset mid-run drops an active read
    lsel = 0; lwr = 1; loe = 0; laddr = 12'h300;
    @(negedge clk);
    check("R3", "read before reset", lq, 8'h42);
    rst_n = 1'b0;
    #1;
    check("R1", "drive cleared by reset", {7'd0, ldrv}, 8'h00);
    check("R1", "data cleared by reset", lq, 8'h00);
    idle();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule